// File: doc/BRIEF.md
# Buffered Flash Program Engine

This block programs a run of consecutive words into a parallel NOR flash device through the device's internal write buffer. A host pulses `start` with a start word address, a word count, the base address of the erase block that holds the run, and the write-buffer size given as a power of two. It then streams the new words in over a valid/ready handshake.

As each word arrives, the engine reads the current contents at that word's target address. It stores the word locally and confirms that programming needs no bit to go from 0 to 1. Only when the whole run has passed this check does the engine raise the programming-power output and begin the command traffic.

The run is cut into buffer-sized chunks. The first chunk stops at the next buffer boundary, so every later chunk starts aligned. For each chunk the engine requests the buffer and retries until the device grants it. It then sends the word count, the data words and the confirm command, and polls status until the device reports ready. The engine always closes the run the same way, after success or after a fault: it clears the status, returns the device to read mode and drops the power. The result is reported as an error code together with the last status byte read.

Top module: `flash_buf_prog`

## Requirements
- R1: A start with a word count of 0, a word count above `MAX_LEN`, or a buffer-size exponent above `WBL_MAX` ends the run with `err_code` 1. No flash read or write is issued, and `prog_pwr` stays low.
- R2: For each accepted word, the engine reads the flash at its target address. If the new word has a 1 in a bit where the current contents hold 0, the run ends with `err_code` 2. No flash write is issued and `prog_pwr` never rises.
- R3: Chunk lengths follow a fixed rule. The first chunk is the smaller of the run length and 2^k − (start mod 2^k). Each later chunk is the smaller of 2^k and the words left.
- R4: To acquire the buffer, the engine writes 0x00E8 to the block base, then reads the block base. It moves on only when bit 7 of that read is 1. Otherwise it repeats the write/read pair.
- R5: If bit 7 is not seen within `ACQ_TMO` cycles, the engine writes 0x0070 to the block base and reads it back. The run ends with `err_code` 3, and `status_out` holds the low byte of that read.
- R6: Once the buffer is granted, the engine writes the chunk length minus one to the block base. It then writes the chunk's words in stream order to consecutive addresses, starting at the chunk's first address, and the flash ends up holding the streamed words.
- R7: After the data, the engine writes 0x00D0 to the block base and polls reads of the block base until bit 7 is 1. If that takes more than `PROG_TMO` cycles, the run ends with `err_code` 4.
- R8: If the ready status has any of bits 1, 3, 4 or 5 set, the run ends with `err_code` 5 and `status_out` equal to that status. No further chunk is started.
- R9: Every run that raised `prog_pwr` ends with a write of 0x0050 and then a write of 0x00FF to the block base. `done` then pulses for one cycle with `prog_pwr` low, and a fully programmed run reports `err_code` 0.
- R10: `prog_pwr` is high during every flash write. It is low out of reset and whenever `done` is high.
- R11: `f_we` and `f_re` are never high together, and `in_ready` is high only while the run is still loading words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| start_addr | input | AW | Word address of the first word |
| word_cnt | input | LW | Number of words in the run |
| blk_base | input | AW | Base word address of the erase block |
| wb_log2 | input | 4 | log2 of the write-buffer size in words |
| in_data | input | DW | Streamed new word |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Engine accepts a word this cycle |
| f_addr | output | AW | Flash word address |
| f_wdata | output | DW | Flash write data |
| f_we | output | 1 | Flash write strobe |
| f_re | output | 1 | Flash read strobe |
| f_rdata | input | DW | Flash read data, valid the cycle after `f_re` |
| prog_pwr | output | 1 | Programming-power enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 3 | 0 ok, 1 bad argument, 2 needs erase, 3 acquire timeout, 4 program timeout, 5 device error |
| status_out | output | 8 | Last status byte read at a timeout or completion |

## Verification
The assertions assume that `f_rdata` follows each `f_re` by exactly one cycle. They also assume that the host holds the run arguments steady only for the `start` cycle. The bench's flash model registers its read data on every strobe and answers from its current mode (array, buffer-grant, or status), so the grant assertion only sees a read value the engine asked for. The stimulus never asks for a write whose count or buffer exponent is out of range, except in the dedicated bad-argument scenario. Each run also uses a fresh address region, so pre-check results never depend on an earlier run.

// File: rtl/flash_buf_prog.sv
module flash_buf_prog #(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int MAX_LEN  = 64,
  parameter int WBL_MAX  = 5,
  parameter int ACQ_TMO  = 200_000_000,
  parameter int PROG_TMO = 200_000_000,
  localparam int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] word_cnt,
  input  logic [AW-1:0] blk_base,
  input  logic [3:0]    wb_log2,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_wdata,
  output logic          f_we,
  output logic          f_re,
  input  logic [DW-1:0] f_rdata,
  output logic          prog_pwr,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err_code,
  output logic [7:0]    status_out
);

  localparam int IW   = $clog2(MAX_LEN);
  localparam int TMAX = (ACQ_TMO > PROG_TMO) ? ACQ_TMO : PROG_TMO;
  localparam int TW   = $clog2(TMAX + 2);

  localparam logic [7:0] C_BUF  = 8'hE8;
  localparam logic [7:0] C_RSR  = 8'h70;
  localparam logic [7:0] C_GO   = 8'hD0;
  localparam logic [7:0] C_CLR  = 8'h50;
  localparam logic [7:0] C_ARR  = 8'hFF;
  localparam logic [7:0] E_MASK = 8'h3A;

  localparam logic [2:0] E_OK = 3'd0, E_ARG = 3'd1, E_ERASE = 3'd2,
                         E_ACQ = 3'd3, E_PROG = 3'd4, E_DEV = 3'd5;

  typedef enum logic [4:0] {
    S_IDLE, S_LD_WAIT, S_LD_CHK,
    S_ACQ_W, S_ACQ_R, S_ACQ_C,
    S_TMO_W, S_TMO_R, S_TMO_C,
    S_CNT_W, S_DAT_W, S_CFM_W,
    S_POLL_R, S_POLL_C,
    S_CLR, S_RST, S_FIN
  } st_t;

  st_t            state;
  logic [AW-1:0]  sa_q, base_q;
  logic [LW-1:0]  len_q, idx, pos, k;
  logic [3:0]     wbl_q;
  logic [TW-1:0]  tmr;
  logic [DW-1:0]  last_w;
  logic           pwr_q;
  logic [2:0]     err_q;
  logic [7:0]     stat_q;
  logic [DW-1:0]  buf_q [MAX_LEN];

  logic [AW-1:0]  cur, wbsize, room;
  logic [LW-1:0]  rem, clen;

  assign cur      = sa_q + AW'(pos);
  assign wbsize   = AW'(1) << wbl_q;
  assign room     = wbsize - (cur & (wbsize - AW'(1)));
  assign rem      = len_q - pos;
  assign clen     = (room < AW'(rem)) ? LW'(room) : rem;

  assign in_ready   = (state == S_LD_WAIT);
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign prog_pwr   = pwr_q;
  assign err_code   = err_q;
  assign status_out = stat_q;

  always_comb begin
    f_we    = 1'b0;
    f_re    = 1'b0;
    f_addr  = base_q;
    f_wdata = '0;
    case (state)
      S_LD_WAIT: begin f_re = in_valid; f_addr = sa_q + AW'(idx); end
      S_ACQ_W:   begin f_we = 1'b1; f_wdata = DW'(C_BUF); end
      S_ACQ_R:   f_re = 1'b1;
      S_TMO_W:   begin f_we = 1'b1; f_wdata = DW'(C_RSR); end
      S_TMO_R:   f_re = 1'b1;
      S_CNT_W:   begin f_we = 1'b1; f_wdata = DW'(clen - LW'(1)); end
      S_DAT_W:   begin
        f_we    = 1'b1;
        f_addr  = cur + AW'(k);
        f_wdata = buf_q[IW'(pos + k)];
      end
      S_CFM_W:   begin f_we = 1'b1; f_wdata = DW'(C_GO); end
      S_POLL_R:  f_re = 1'b1;
      S_CLR:     begin f_we = 1'b1; f_wdata = DW'(C_CLR); end
      S_RST:     begin f_we = 1'b1; f_wdata = DW'(C_ARR); end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (state == S_LD_WAIT && in_valid)
      buf_q[IW'(idx)] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sa_q   <= '0;
      base_q <= '0;
      len_q  <= '0;
      wbl_q  <= '0;
      idx    <= '0;
      pos    <= '0;
      k      <= '0;
      tmr    <= '0;
      last_w <= '0;
      pwr_q  <= 1'b0;
      err_q  <= E_OK;
      stat_q <= '0;
    end else begin
      if ((state == S_ACQ_W || state == S_ACQ_R || state == S_ACQ_C ||
           state == S_POLL_R || state == S_POLL_C) && tmr != '1)
        tmr <= tmr + TW'(1);
      case (state)
        S_IDLE: if (start) begin
          sa_q   <= start_addr;
          base_q <= blk_base;
          len_q  <= word_cnt;
          wbl_q  <= wb_log2;
          idx    <= '0;
          pos    <= '0;
          err_q  <= E_OK;
          stat_q <= '0;
          if (word_cnt == '0 || int'(word_cnt) > MAX_LEN || int'(wb_log2) > WBL_MAX) begin
            err_q <= E_ARG;
            state <= S_FIN;
          end else begin
            state <= S_LD_WAIT;
          end
        end
        S_LD_WAIT: if (in_valid) begin
          last_w <= in_data;
          state  <= S_LD_CHK;
        end
        S_LD_CHK: begin
          if ((last_w & f_rdata) != last_w) begin
            err_q <= E_ERASE;
            state <= S_FIN;
          end else if (idx == len_q - LW'(1)) begin
            pwr_q <= 1'b1;
            tmr   <= '0;
            state <= S_ACQ_W;
          end else begin
            idx   <= idx + LW'(1);
            state <= S_LD_WAIT;
          end
        end
        S_ACQ_W: state <= S_ACQ_R;
        S_ACQ_R: state <= S_ACQ_C;
        S_ACQ_C: begin
          if (f_rdata[7])                  state <= S_CNT_W;
          else if (tmr >= TW'(ACQ_TMO))    state <= S_TMO_W;
          else                             state <= S_ACQ_W;
        end
        S_TMO_W: state <= S_TMO_R;
        S_TMO_R: state <= S_TMO_C;
        S_TMO_C: begin
          stat_q <= f_rdata[7:0];
          err_q  <= E_ACQ;
          state  <= S_CLR;
        end
        S_CNT_W: begin
          k     <= '0;
          state <= S_DAT_W;
        end
        S_DAT_W: begin
          k <= k + LW'(1);
          if (k == clen - LW'(1)) state <= S_CFM_W;
        end
        S_CFM_W: begin
          tmr   <= '0;
          state <= S_POLL_R;
        end
        S_POLL_R: state <= S_POLL_C;
        S_POLL_C: begin
          if (f_rdata[7]) begin
            stat_q <= f_rdata[7:0];
            if ((f_rdata[7:0] & E_MASK) != 8'h00) begin
              err_q <= E_DEV;
              state <= S_CLR;
            end else begin
              pos <= pos + clen;
              tmr <= '0;
              state <= (pos + clen == len_q) ? S_CLR : S_ACQ_W;
            end
          end else if (tmr >= TW'(PROG_TMO)) begin
            stat_q <= f_rdata[7:0];
            err_q  <= E_PROG;
            state  <= S_CLR;
          end else begin
            state <= S_POLL_R;
          end
        end
        S_CLR: state <= S_RST;
        S_RST: begin
          pwr_q <= 1'b0;
          state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_we && f_re));

  assert_ready_only_loading_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !prog_pwr));

  assert_write_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    f_we |-> prog_pwr);

  assert_done_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !prog_pwr);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_reset_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (f_we && state == S_CLR) |=> (f_we && f_wdata[7:0] == C_ARR));

  assert_count_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CNT_W) |-> $past(f_rdata[7]));

  assert_no_write_on_erase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_q == E_ERASE) |-> $past(!prog_pwr));

endmodule

// File: tb/test_flash_buf_prog.sv
module test_flash_buf_prog;
  localparam int AW = 12, DW = 16, ML = 64, WBM = 5, AT = 50, PT = 60;
  localparam int LW = $clog2(ML + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] word_cnt = '0;
  logic [AW-1:0] blk_base = '0;
  logic [3:0]    wb_log2 = '0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_wdata;
  logic          f_we, f_re;
  logic [DW-1:0] f_rdata;
  logic          prog_pwr, busy, done;
  logic [2:0]    err_code;
  logic [7:0]    status_out;

  flash_buf_prog #(.AW(AW), .DW(DW), .MAX_LEN(ML), .WBL_MAX(WBM),
                   .ACQ_TMO(AT), .PROG_TMO(PT)) i_flash_buf_prog (.*);

  int total = 0, bad = 0;

  // flash model
  logic [DW-1:0] mem [256];
  int mode = 0, phase = 0, n_left = 0, prog_busy = 0, granted = 0;
  int ne8 = 0, nre = 0, nw = 0, ncnt = 0, pwr_cyc = 0, ndone = 0;
  int e8_mark = 0, deny_n = 0;
  bit deny_all = 0, hang = 0;
  logic [7:0] inj = 8'h00;
  logic [DW-1:0] wl_d [1024];
  int cnt_log [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
      mem[8'h90] = 16'h00F0;
      mode = 0; phase = 0; f_rdata <= '0;
    end else begin
      if (prog_busy > 0) prog_busy--;
      if (prog_pwr) pwr_cyc++;
      if (done) ndone++;
      if (f_re) begin
        nre++;
        if (mode == 0) f_rdata <= mem[f_addr[7:0]];
        else if (mode == 1) begin
          f_rdata <= granted ? 16'h0080 : 16'h0000;
          if (granted) phase = 1;
        end else
          f_rdata <= (prog_busy > 0 || hang) ? 16'h0000 : {8'h00, 8'h80 | inj};
      end
      if (f_we) begin
        if (nw < 1024) wl_d[nw] = f_wdata;
        nw++;
        if (phase == 1) begin
          if (ncnt < 256) cnt_log[ncnt] = int'(f_wdata);
          ncnt++;
          n_left = int'(f_wdata) + 1;
          phase = 2;
        end else if (phase == 2) begin
          mem[f_addr[7:0]] = mem[f_addr[7:0]] & f_wdata;
          n_left--;
          if (n_left == 0) phase = 3;
        end else if (phase == 3) begin
          phase = 0;
          if (f_wdata[7:0] == 8'hD0) begin mode = 2; prog_busy = 3; end
        end else begin
          case (f_wdata[7:0])
            8'hE8: begin
              granted = (!deny_all && (ne8 - e8_mark) >= deny_n) ? 1 : 0;
              ne8++;
              mode = 1;
            end
            8'h70: mode = 2;
            8'hFF: mode = 0;
            default: ;
          endcase
        end
      end
    end
  end

  int nw0, ncnt0, pwr0, d0, nre0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int sa, input int len, input int wbl, input logic [15:0] pat);
    nw0 = nw; ncnt0 = ncnt; pwr0 = pwr_cyc; d0 = ndone; nre0 = nre; e8_mark = ne8;
    @(negedge clk);
    start = 1'b1; start_addr = AW'(sa); word_cnt = LW'(len);
    blk_base = '0; wb_log2 = 4'(wbl);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len && ndone == d0; i++) begin
      in_valid = 1'b1;
      in_data  = pat + 16'(i);
      while (!in_ready && ndone == d0) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (ndone == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_mem(input int sa, input int len, input logic [15:0] pat, input string req);
    for (int i = 0; i < len; i++)
      chk(mem[8'(sa + i)] == pat + 16'(i), req, int'(mem[8'(sa + i)]), int'(pat + 16'(i)));
  endtask

  task automatic chk_chunks(input int sa, input int len, input int wbl, input string req);
    int p = 0, n = 0;
    while (p < len) begin
      int wb = 1 << wbl;
      int room = wb - ((sa + p) % wb);
      int c = (room < len - p) ? room : len - p;
      chk(ncnt0 + n < ncnt && cnt_log[ncnt0 + n] == c - 1, req, cnt_log[ncnt0 + n], c - 1);
      p += c; n++;
    end
    chk(ncnt - ncnt0 == n, req, ncnt - ncnt0, n);
  endtask

  task automatic chk_close(input string req);
    chk(nw - nw0 >= 2 && wl_d[nw-2][7:0] == 8'h50 && wl_d[nw-1][7:0] == 8'hFF,
        req, int'(wl_d[nw-1]), 16'hFF);
    chk(!prog_pwr, req, int'(prog_pwr), 0);
  endtask

  task automatic t_reset;
    chk(!busy && !prog_pwr && !f_we && !f_re && !in_ready && err_code == 3'd0,
        "R10 reset state", int'({busy, prog_pwr, f_we, f_re, in_ready}), 0);
  endtask

  task automatic t_aligned;
    run(32'h20, 8, 2, 16'h1234);
    chk(err_code == 3'd0, "R9 aligned ok", int'(err_code), 0);
    chk_chunks(32'h20, 8, 2, "R3 aligned chunks");
    chk_mem(32'h20, 8, 16'h1234, "R6 aligned data");
    chk_close("R9 aligned close");
  endtask

  task automatic t_unaligned;
    run(32'h33, 10, 3, 16'h5A00);
    chk(err_code == 3'd0, "R3 unaligned ok", int'(err_code), 0);
    chk_chunks(32'h33, 10, 3, "R3 unaligned chunks");
    chk_mem(32'h33, 10, 16'h5A00, "R6 unaligned data");
  endtask

  task automatic t_short;
    run(32'h41, 2, 3, 16'h0C0C);
    chk_chunks(32'h41, 2, 3, "R3 short run");
    chk_mem(32'h41, 2, 16'h0C0C, "R6 short data");
  endtask

  task automatic t_retry;
    deny_n = 3;
    run(32'h50, 4, 2, 16'h7700);
    deny_n = 0;
    chk(err_code == 3'd0, "R4 retry ok", int'(err_code), 0);
    chk(ne8 - e8_mark == 4, "R4 request count", ne8 - e8_mark, 4);
    chk_mem(32'h50, 4, 16'h7700, "R4 retry data");
  endtask

  task automatic t_erase;
    run(32'h8E, 4, 2, 16'h0F0F);
    chk(err_code == 3'd2, "R2 needs erase code", int'(err_code), 2);
    chk(nw == nw0, "R2 no write", nw - nw0, 0);
    chk(pwr_cyc == pwr0, "R2 power stayed low", pwr_cyc - pwr0, 0);
    chk(mem[8'h90] == 16'h00F0, "R2 cell untouched", int'(mem[8'h90]), 16'h00F0);
  endtask

  task automatic t_acq_to;
    deny_all = 1; inj = 8'h02;
    run(32'hA0, 4, 2, 16'h1111);
    deny_all = 0; inj = 8'h00;
    chk(err_code == 3'd3, "R5 acquire timeout code", int'(err_code), 3);
    chk(status_out == 8'h82, "R5 captured status", int'(status_out), 8'h82);
    chk(ne8 - e8_mark >= 2, "R4 repeated request", ne8 - e8_mark, 2);
    chk(ncnt == ncnt0, "R5 no count write", ncnt - ncnt0, 0);
    chk(nw - nw0 >= 3 && wl_d[nw-3][7:0] == 8'h70, "R5 status command", int'(wl_d[nw-3]), 16'h70);
    chk_close("R9 close after acquire timeout");
  endtask

  task automatic t_prog_to;
    hang = 1;
    run(32'hB0, 4, 2, 16'h2222);
    hang = 0;
    chk(err_code == 3'd4, "R7 program timeout code", int'(err_code), 4);
    chk_close("R9 close after program timeout");
  endtask

  task automatic t_dev_err;
    inj = 8'h10;
    run(32'h60, 8, 2, 16'h3300);
    inj = 8'h00;
    chk(err_code == 3'd5, "R8 device error code", int'(err_code), 5);
    chk(status_out == 8'h90, "R8 status value", int'(status_out), 8'h90);
    chk(ncnt - ncnt0 == 1, "R8 no further chunk", ncnt - ncnt0, 1);
    chk(mem[8'h64] == 16'hFFFF, "R8 second chunk untouched", int'(mem[8'h64]), 16'hFFFF);
    chk_close("R9 close after device error");
  endtask

  task automatic t_badarg;
    run(32'hC0, 0, 2, 16'h0);
    chk(err_code == 3'd1, "R1 zero length", int'(err_code), 1);
    chk(nw == nw0 && nre == nre0, "R1 no flash access", nw - nw0 + nre - nre0, 0);
    run(32'hC0, 4, 7, 16'h0);
    chk(err_code == 3'd1, "R1 buffer size too big", int'(err_code), 1);
    chk(nw == nw0 && pwr_cyc == pwr0, "R1 no write or power", nw - nw0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_aligned;
    t_unaligned;
    t_short;
    t_retry;
    t_erase;
    t_acq_to;
    t_prog_to;
    t_dev_err;
    t_badarg;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule